// File: doc/BRIEF.md
# DRAM Keep-Alive Sequencer (Start-Up and Refresh Pacing)

This block keeps the contents of an asynchronous DRAM alive and brings the device up after power is applied. When reset is released it holds both strobes high for a start-up pause. It then runs a fixed number of wake-up cycles, each containing one row-strobe pulse. From then on it issues CAS-before-RAS refresh cycles at an even rate. Row-address counting happens inside the memory, so the block drives only the two strobes. Write enable, output enable, address and data stay with the access controller, which leaves data undriven while a refresh owns the bus.

The block shares the strobes with the access controller through a request/grant pair. It raises `ref_req` when it needs the bus. It starts strobing only after it has seen `ref_gnt` high, and it lowers `ref_req` once precharge is over. Refreshes that fall due while the grant is held back are counted as owed and then issued back to back. When the owed count reaches a threshold, `ref_urgent` tells the controller to put refresh ahead of host traffic. The controller also reports each of its own row-strobe cycles on `host_ras_act`. If neither party has pulsed the row strobe for a whole lapse window, the block lowers `init_done` and runs the wake-up sequence again. The host must not start accesses while `init_done` is low.

All times are in clock cycles. With a 100 MHz clock, realistic settings are a pause of 20000 cycles, a refresh period of 1560 cycles (512 rows in 8 ms) and a lapse window of 800000 cycles. The defaults are small so that a simulation stays short.

The controller has six states:
- ST_PAUSE: the start-up wait.
- ST_IDLE: nothing is owed.
- ST_ASK: request raised, waiting for the grant.
- ST_CAS_LEAD: column strobe low ahead of the row strobe.
- ST_RAS_ACT: both strobes low.
- ST_PRECH: both strobes high, bus still held.

Its transitions are:
- pause expiry: ST_PAUSE to ST_ASK.
- demand: ST_IDLE to ST_ASK, when waking or a refresh is owed.
- grant: ST_ASK to ST_CAS_LEAD.
- lead done: ST_CAS_LEAD to ST_RAS_ACT.
- pulse done: ST_RAS_ACT to ST_PRECH.
- release: ST_PRECH to ST_IDLE.

Top module: `dram_keepalive_seq`

## Requirements
- R1: From reset release, `ras_n` and `cas_n` stay high and `ref_req` and `init_done` stay low. `ref_req` first rises on the PAUSE_CYC-th rising clock edge after reset release.
- R2: After the pause, `init_done` rises only after exactly WAKE_N row-strobe pulses.
- R3: In every refresh cycle, `cas_n` is low for exactly CSR_CYC cycles before `ras_n` falls. Both strobes then stay low for exactly RAS_CYC cycles and rise on the same clock edge.
- R4: Between the rise of `ras_n` and the next fall of `cas_n`, both strobes stay high for at least RP_CYC cycles.
- R5: `cas_n` falls only on an edge where `ref_gnt` was sampled high. `ref_req` stays high for as long as `ras_n` is low.
- R6: While the grant is given promptly, exactly one refresh is issued per REF_PERIOD cycles on average.
- R7: Each REF_PERIOD elapsed after `init_done` adds one owed refresh. Owed refreshes are issued back to back once granted. The owed count saturates at 2^DEBT_W-1.
- R8: `ref_urgent` is high exactly while the owed count is URGENT_LVL or more.
- R9: If `init_done` is high and no row-strobe fall (own, or a `host_ras_act` pulse) occurs for LAPSE_CYC cycles, then `init_done` falls, the owed count clears and WAKE_N wake-up cycles run again.
- R10: A one-cycle `host_ras_act` pulse restarts the lapse window, even while the grant is withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| ref_gnt | input | 1 | bus grant from the access controller |
| host_ras_act | input | 1 | one-cycle pulse per host row-strobe cycle |
| ref_req | output | 1 | bus request; stays high until precharge ends |
| ref_urgent | output | 1 | owed refreshes have reached the threshold |
| ras_n | output | 1 | row strobe, active low |
| cas_n | output | 1 | column strobe, active low |
| init_done | output | 1 | wake-up finished; host access allowed |

## Verification
The assertions take it for granted that the controller raises `ref_gnt` only while `ref_req` is high and holds it there until `ref_req` drops. The lead and width checks also rely on the grant never being withdrawn in the middle of a cycle. The stimulus drives the grant from a bench process that keeps this protocol: it waits a random 0 to 7 cycles after a request, or withholds the grant completely during the debt, lapse and host-pulse scenarios. `host_ras_act` is only ever pulsed for a single cycle, which the lapse window assumes.

// File: rtl/ka_pkg.sv
package ka_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_ASK,
        ST_CAS_LEAD,
        ST_RAS_ACT,
        ST_PRECH
    } ka_state_t;

    function automatic int clog2w(input int v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ka_interval_timer.sv
module ka_interval_timer #(
    parameter int PERIOD = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic tick
);
    localparam int W = ka_pkg::clog2w(PERIOD);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !en) begin
            cnt <= '0;
        end else if (cnt == W'(PERIOD - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && !clr && (cnt == W'(PERIOD - 1));

endmodule

// File: rtl/ka_debt_ledger.sv
module ka_debt_ledger #(
    parameter int DEBT_W     = 3,
    parameter int URGENT_LVL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic add,
    input  logic sub,
    output logic pending,
    output logic urgent
);
    localparam logic [DEBT_W-1:0] FULL = {DEBT_W{1'b1}};

    logic [DEBT_W-1:0] owed;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            owed <= '0;
        end else begin
            unique case ({add, sub})
                2'b10:   if (owed != FULL) owed <= owed + 1'b1;
                2'b01:   if (owed != '0)   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assign pending = (owed != '0);
    assign urgent  = (owed >= DEBT_W'(URGENT_LVL));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub |-> (owed != '0));

endmodule

// File: rtl/ka_strobe_fsm.sv
module ka_strobe_fsm #(
    parameter int PAUSE_CYC = 50,
    parameter int WAKE_N    = 8,
    parameter int CSR_CYC   = 2,
    parameter int RAS_CYC   = 4,
    parameter int RP_CYC    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt,
    input  logic need_ref,
    input  logic lapse,
    output logic ras_n,
    output logic cas_n,
    output logic req,
    output logic init_done,
    output logic cyc_done,
    output logic ras_fall
);
    import ka_pkg::*;

    localparam int CW = clog2w(max4(PAUSE_CYC, CSR_CYC, RAS_CYC, RP_CYC));
    localparam int WW = clog2w(WAKE_N + 1);
    localparam int RW = CW + 1;

    ka_state_t     state, state_nx;
    logic [CW-1:0] phase, phase_nx;
    logic          waking;
    logic [WW-1:0] wake_left;
    logic          cyc_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PAUSE;
            phase <= CW'(PAUSE_CYC - 1);
        end else begin
            state <= state_nx;
            phase <= phase_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        phase_nx = phase;
        unique case (state)
            ST_PAUSE: begin
                if (phase == '0) state_nx = ST_ASK;
                else             phase_nx = phase - 1'b1;
            end
            ST_IDLE: begin
                if (waking || need_ref) state_nx = ST_ASK;
            end
            ST_ASK: begin
                if (gnt) begin
                    state_nx = ST_CAS_LEAD;
                    phase_nx = CW'(CSR_CYC - 1);
                end
            end
            ST_CAS_LEAD: begin
                if (phase == '0) begin
                    state_nx = ST_RAS_ACT;
                    phase_nx = CW'(RAS_CYC - 1);
                end else begin
                    phase_nx = phase - 1'b1;
                end
            end
            ST_RAS_ACT: begin
                if (phase == '0) begin
                    state_nx = ST_PRECH;
                    phase_nx = CW'(RP_CYC - 1);
                end else begin
                    phase_nx = phase - 1'b1;
                end
            end
            ST_PRECH: begin
                if (phase == '0) state_nx = ST_IDLE;
                else             phase_nx = phase - 1'b1;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        req   = 1'b0;
        unique case (state)
            ST_PAUSE, ST_IDLE: begin
                req = 1'b0;
            end
            ST_ASK, ST_PRECH: begin
                req = 1'b1;
            end
            ST_CAS_LEAD: begin
                req   = 1'b1;
                cas_n = 1'b0;
            end
            ST_RAS_ACT: begin
                req   = 1'b1;
                cas_n = 1'b0;
                ras_n = 1'b0;
            end
            default: req = 1'b0;
        endcase
    end

    assign cyc_end  = (state == ST_PRECH) && (phase == '0);
    assign ras_fall = (state == ST_CAS_LEAD) && (phase == '0);

    // wake-up bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waking    <= 1'b1;
            wake_left <= WW'(WAKE_N);
        end else if (lapse && !waking) begin
            waking    <= 1'b1;
            wake_left <= WW'(WAKE_N);
        end else if (cyc_end && waking) begin
            if (wake_left == WW'(1)) waking <= 1'b0;
            wake_left <= wake_left - 1'b1;
        end
    end

    assign init_done = !waking;
    assign cyc_done  = cyc_end && !waking;

    // checker: row-strobe low-time counter
    logic [RW-1:0] ras_w;
    always_ff @(posedge clk) begin
        if (!rst_n)      ras_w <= '0;
        else if (!ras_n) ras_w <= ras_w + 1'b1;
        else             ras_w <= '0;
    end

    // R3
    cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    // R3
    cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R3
    ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_w == RW'(RAS_CYC)));

    // R5
    grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(gnt && req));

    // R2
    init_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(req));

endmodule

// File: rtl/dram_keepalive_seq.sv
module dram_keepalive_seq #(
    parameter int PAUSE_CYC  = 50,
    parameter int WAKE_N     = 8,
    parameter int REF_PERIOD = 40,
    parameter int LAPSE_CYC  = 600,
    parameter int CSR_CYC    = 2,
    parameter int RAS_CYC    = 4,
    parameter int RP_CYC     = 3,
    parameter int DEBT_W     = 3,
    parameter int URGENT_LVL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    input  logic host_ras_act,
    output logic ref_req,
    output logic ref_urgent,
    output logic ras_n,
    output logic cas_n,
    output logic init_done
);
    logic pace_tick;
    logic lapse;
    logic pending;
    logic cyc_done;
    logic ras_fall;

    ka_interval_timer #(.PERIOD(REF_PERIOD)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .clr   (1'b0),
        .tick  (pace_tick)
    );

    ka_interval_timer #(.PERIOD(LAPSE_CYC)) u_lapse (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .clr   (ras_fall | host_ras_act),
        .tick  (lapse)
    );

    ka_debt_ledger #(.DEBT_W(DEBT_W), .URGENT_LVL(URGENT_LVL)) u_ledger (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!init_done),
        .add     (pace_tick),
        .sub     (cyc_done),
        .pending (pending),
        .urgent  (ref_urgent)
    );

    ka_strobe_fsm #(
        .PAUSE_CYC (PAUSE_CYC),
        .WAKE_N    (WAKE_N),
        .CSR_CYC   (CSR_CYC),
        .RAS_CYC   (RAS_CYC),
        .RP_CYC    (RP_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt       (ref_gnt),
        .need_ref  (pending),
        .lapse     (lapse),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .req       (ref_req),
        .init_done (init_done),
        .cyc_done  (cyc_done),
        .ras_fall  (ras_fall)
    );

    // R9
    lapse_rewake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_done) |-> $past(lapse));

endmodule

// File: tb/dram_keepalive_seq_tb.sv
module dram_keepalive_seq_tb;
    localparam int PAUSE_CYC  = 50;
    localparam int WAKE_N     = 8;
    localparam int REF_PERIOD = 40;
    localparam int LAPSE_CYC  = 600;
    localparam int CSR_CYC    = 2;
    localparam int RAS_CYC    = 4;
    localparam int RP_CYC     = 3;
    localparam int DEBT_W     = 3;
    localparam int URGENT_LVL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic host_ras_act = 1'b0;
    logic ref_req, ref_urgent, ras_n, cas_n, init_done;

    always #5 clk = ~clk;

    dram_keepalive_seq #(
        .PAUSE_CYC(PAUSE_CYC), .WAKE_N(WAKE_N), .REF_PERIOD(REF_PERIOD),
        .LAPSE_CYC(LAPSE_CYC), .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC),
        .RP_CYC(RP_CYC), .DEBT_W(DEBT_W), .URGENT_LVL(URGENT_LVL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .host_ras_act(host_ras_act),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .ras_n(ras_n), .cas_n(cas_n),
        .init_done(init_done)
    );

    int checks = 0;
    int fails  = 0;
    int ras_falls = 0;
    bit hold = 1'b0;
    int wait_left = 0;
    bit gnt_q = 1'b0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // expected values from the requirements
    function automatic int exp_pause_lows();
        return PAUSE_CYC - 1;
    endfunction
    function automatic int debt_max();
        return (1 << DEBT_W) - 1;
    endfunction
    function automatic int owed_lo(input int held_p, input int drain_p);
        int o;
        o = (held_p > debt_max()) ? debt_max() : held_p;
        return o + drain_p - 1;
    endfunction
    function automatic int owed_hi(input int held_p, input int drain_p);
        int o;
        o = (held_p + 1 > debt_max()) ? debt_max() : held_p + 1;
        return o + drain_p + 1;
    endfunction

    // grant driver: random latency, withheld while hold is set
    always @(negedge clk) begin
        if (!rst_n || !ref_req) begin
            ref_gnt   <= 1'b0;
            wait_left <= int'($urandom_range(0, 7));
        end else if (!ref_gnt && !hold) begin
            if (wait_left == 0) ref_gnt <= 1'b1;
            else                wait_left <= wait_left - 1;
        end
    end

    always @(posedge clk) gnt_q <= ref_gnt;

    // strobe monitor
    bit prev_ras = 1'b1, prev_cas = 1'b1, seen_rise = 1'b0;
    int lead_run = 0, low_run = 0, hi_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                ras_falls++;
                chk(lead_run == CSR_CYC, "R3 lead", lead_run, CSR_CYC);
            end
            if (!prev_ras && ras_n) begin
                chk(low_run == RAS_CYC, "R3 width", low_run, RAS_CYC);
                chk(cas_n == 1'b1, "R3 joint rise", int'(cas_n), 1);
                seen_rise = 1'b1;
            end
            if (prev_cas && !cas_n) begin
                if (seen_rise) chk(hi_run >= RP_CYC, "R4 precharge", hi_run, RP_CYC);
                chk(gnt_q == 1'b1, "R5 grant", int'(gnt_q), 1);
            end
            if (!ras_n) chk(ref_req == 1'b1, "R5 req held", int'(ref_req), 1);
            lead_run = (!cas_n && ras_n) ? lead_run + 1 : 0;
            low_run  = (!ras_n) ? low_run + 1 : 0;
            hi_run   = (ras_n && cas_n) ? hi_run + 1 : 0;
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_req_low();
        int g = 0;
        while (ref_req && g < 2000) begin step(); g++; end
    endtask

    task automatic wait_init(input string rq);
        int g = 0;
        while (!init_done && g < 5000) begin step(); g++; end
        chk(init_done == 1'b1, rq, int'(init_done), 1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int f0, lows, n;
        void'($urandom(32'h5EED));
        repeat (5) step();
        // R1 reset state
        chk(ras_n && cas_n, "R1 strobes in reset", int'({ras_n, cas_n}), 3);
        chk(!ref_req && !init_done, "R1 req/init in reset", int'({ref_req, init_done}), 0);
        rst_n = 1'b1;
        lows = 0;
        step();
        while (!ref_req && lows < 1000) begin
            if (!(ras_n && cas_n && !init_done)) chk(1'b0, "R1 quiet pause", int'({ras_n, cas_n, init_done}), 6);
            lows++;
            step();
        end
        chk(lows == exp_pause_lows(), "R1 pause length", lows, exp_pause_lows());

        // R2 wake-up count
        f0 = ras_falls;
        wait_init("R2 init_done rises");
        chk(ras_falls - f0 == WAKE_N, "R2 wake pulses", ras_falls - f0, WAKE_N);

        // R6 pacing with random grant latency
        repeat (3 * REF_PERIOD) step();
        f0 = ras_falls;
        repeat (20 * REF_PERIOD) step();
        n = ras_falls - f0;
        chk(n >= 19 && n <= 21, "R6 refresh rate", n, 20);

        // R7 small backlog
        wait_req_low();
        hold = 1'b1;
        f0 = ras_falls;
        repeat (3 * REF_PERIOD) step();
        chk(ras_falls == f0, "R7 no strobe while withheld", ras_falls - f0, 0);
        hold = 1'b0;
        repeat (4 * REF_PERIOD) step();
        n = ras_falls - f0;
        chk(n >= owed_lo(3, 4) && n <= owed_hi(3, 4), "R7 backlog drained", n, owed_lo(3, 4));

        // R7 saturation, R8 urgency
        wait_req_low();
        hold = 1'b1;
        f0 = ras_falls;
        repeat (REF_PERIOD + REF_PERIOD / 2) step();
        chk(ref_urgent == 1'b0, "R8 not urgent below level", int'(ref_urgent), 0);
        repeat (3 * REF_PERIOD + REF_PERIOD / 2) step();
        chk(ref_urgent == 1'b1, "R8 urgent at level", int'(ref_urgent), 1);
        repeat (7 * REF_PERIOD) step();
        hold = 1'b0;
        repeat (8 * REF_PERIOD) step();
        n = ras_falls - f0;
        chk(n >= owed_lo(12, 8) && n <= owed_hi(12, 8), "R7 saturation", n, owed_lo(12, 8));

        // R9 lapse and re-wake
        wait_req_low();
        hold = 1'b1;
        repeat (LAPSE_CYC - REF_PERIOD - 20) step();
        chk(init_done == 1'b1, "R9 alive before lapse", int'(init_done), 1);
        chk(ref_urgent == 1'b1, "R8 urgent while withheld", int'(ref_urgent), 1);
        repeat (REF_PERIOD + 25) step();
        chk(init_done == 1'b0, "R9 init_done dropped", int'(init_done), 0);
        chk(ref_urgent == 1'b0, "R9 owed cleared", int'(ref_urgent), 0);
        f0 = ras_falls;
        hold = 1'b0;
        wait_init("R9 re-wake completes");
        chk(ras_falls - f0 == WAKE_N, "R9 re-wake pulses", ras_falls - f0, WAKE_N);

        // R10 host pulses keep it alive
        wait_req_low();
        hold = 1'b1;
        for (int k = 0; k < 12; k++) begin
            repeat (90) step();
            host_ras_act = 1'b1;
            step();
            host_ras_act = 1'b0;
            if (!init_done) chk(1'b0, "R10 alive with host pulses", k, 12);
        end
        chk(init_done == 1'b1, "R10 alive after long hold", int'(init_done), 1);
        hold = 1'b0;
        repeat (10 * REF_PERIOD) step();
        chk(ref_urgent == 1'b0, "R7 drained after hold", int'(ref_urgent), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule